// File: doc/BRIEF.md
# Video field CRC generator and checker

This block computes two 16-bit check values for every video field from a stream of 10-bit words. One value covers the active picture region and the other covers the full field. The surrounding line and sample counter marks which words fall in each region, using one enable per region. It also marks where each field starts and ends. The block keeps no knowledge of line or sample positions of its own.

In receive mode, the packet parser upstream delivers the check words it has recovered from the incoming error packet through a small load port. At the end of each field the block compares both computed values with the received ones. It then reports a mismatch flag and the received valid bit for each region. In transmit mode the received values are ignored and no flags are raised. In both modes the two computed values are kept for one field. They are also presented as three 10-bit packet words per region, ready to be inserted into the outgoing packet.

Top module: `field_crc_gen`

## Requirements
- R1: Each region value uses the polynomial x^16 + x^12 + x^5 + 1 (0x1021). The register is preset to zero. All 10 bits of each word are shifted in, bit 0 first. For each bit, the feedback is the data bit XOR register bit 15. The register then shifts left, and 0x1021 is XORed in when the feedback is 1.
- R2: An input word from 3FC to 3FF inclusive enters the update as 3FF. A word of 3FB or below enters the update unchanged.
- R3: A word updates the active picture value only when `ap_en` is high in its cycle. It updates the full field value only when `ff_en` is high. Words outside a region have no effect on that region's value, and an empty region yields 0000.
- R4: When `field_start` is high, both registers restart from zero before that cycle's word is taken in. Words taken in before the restart do not affect the result.
- R5: The cycle after `field_end` is sampled, `res_vld` is high for exactly one cycle. In that cycle, `ap_crc` and `ff_crc` hold the values that include the word of the `field_end` cycle. All results then hold until the next `field_end`. After reset, every output flag and value is zero.
- R6: Each region value goes out as three words. Word k (k = 0, 1, 2) carries value bits 6k to 6k+5 in word bits 2 to 7; the bits above bit 15 are zero. Bits 0 and 1 are zero. In words 0 and 1, bit 8 is even parity over bits 0 to 7. In word 2, bit 8 is the valid bit, which is always 1. Bit 9 is the inverse of bit 8. `tx_*_pk` holds word 0 in bits 9:0, word 1 in 19:10 and word 2 in 29:20.
- R7: In receive mode, if a region's received valid bit is 1 at `field_end`, that region's mismatch flag is set whenever the received value differs from the computed value. Slots 0 to 2 of `pk_sel` load active picture words 0 to 2. Slots 3 to 5 load full field words 0 to 2, with the same field positions as in R6.
- R8: The received valid bit is taken from bit 8 of word 2 and reported on `*_rxv` at the result. A region whose valid bit is 0 never reports a mismatch. Received valid bits clear at every `field_end`, so a field with no packet reports valid 0 and no mismatch.
- R9: In transmit mode (`rx_mode` = 0), the mismatch and valid outputs are 0 at every result, whatever packet words were loaded.
- R10: A loaded packet word is dropped unless bit 9 is the inverse of bit 8 and bits 1:0 are zero. A dropped word leaves the stored value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_mode | input | 1 | 1 = receive (compare), 0 = transmit |
| din | input | 10 | Video word for this cycle |
| ap_en | input | 1 | Word belongs to active picture region |
| ff_en | input | 1 | Word belongs to full field region |
| field_start | input | 1 | Restart both registers this cycle |
| field_end | input | 1 | Close the field and capture results |
| pk_ld | input | 1 | Load one received packet word |
| pk_sel | input | 3 | Slot of the loaded word (0..5) |
| pk_word | input | 10 | Received packet word |
| res_vld | output | 1 | One-cycle pulse: new results present |
| ap_crc | output | 16 | Active picture value of last field |
| ff_crc | output | 16 | Full field value of last field |
| ap_mis | output | 1 | Active picture mismatch |
| ff_mis | output | 1 | Full field mismatch |
| ap_rxv | output | 1 | Received active picture valid bit |
| ff_rxv | output | 1 | Received full field valid bit |
| tx_ap_pk | output | 30 | Three packed active picture words |
| tx_ff_pk | output | 30 | Three packed full field words |

## Verification
Every result of a field is registered once, on the edge that samples `field_end`. The compared values, the flags, the valid bits and the packed words are therefore all due one cycle later, together with `res_vld`. The driver computes the expected record while it feeds the field and queues it before it raises `field_end`. The monitor pops and compares it at the falling edge where `res_vld` is high, half a cycle after the outputs settle. Two cycles after that, the driver confirms that the pulse has ended and the values still hold. Packet words and window words are driven at falling edges, so each one is sampled on the next rising edge.

// File: rtl/field_crc_gen.sv
module field_crc_gen #(
  parameter int DW = 10,
  parameter int CW = 16,
  parameter int CHUNK = 6,
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_mode,
  input  logic [DW-1:0]      din,
  input  logic               ap_en,
  input  logic               ff_en,
  input  logic               field_start,
  input  logic               field_end,
  input  logic               pk_ld,
  input  logic [2:0]         pk_sel,
  input  logic [DW-1:0]      pk_word,
  output logic               res_vld,
  output logic [CW-1:0]      ap_crc,
  output logic [CW-1:0]      ff_crc,
  output logic               ap_mis,
  output logic               ff_mis,
  output logic               ap_rxv,
  output logic               ff_rxv,
  output logic [3*DW-1:0]    tx_ap_pk,
  output logic [3*DW-1:0]    tx_ff_pk
);

  localparam int NW = 3;
  localparam int XW = NW * CHUNK;

  function automatic logic [CW-1:0] crc_step(input logic [CW-1:0] c, input logic [DW-1:0] w);
    logic [DW-1:0] r;
    logic [CW-1:0] s;
    logic fb;
    r = (&w[DW-1:2]) ? '1 : w;
    s = c;
    for (int i = 0; i < DW; i++) begin
      fb = r[i] ^ s[CW-1];
      s = {s[CW-2:0], 1'b0} ^ (fb ? POLY[CW-1:0] : '0);
    end
    return s;
  endfunction

  function automatic logic [NW*DW-1:0] pack(input logic [CW-1:0] c, input logic v);
    logic [XW-1:0] x;
    logic [NW*DW-1:0] o;
    logic [CHUNK-1:0] ch;
    logic b8;
    x = XW'(c);
    for (int k = 0; k < NW; k++) begin
      ch = x[k*CHUNK +: CHUNK];
      b8 = (k == NW-1) ? v : ^ch;
      o[k*DW +: DW] = {~b8, b8, ch, 2'b00};
    end
    return o;
  endfunction

  logic [CW-1:0] ap_acc, ff_acc;
  logic [XW-1:0] rx_ap_x, rx_ff_x;
  logic          rx_ap_v, rx_ff_v;

  wire [CW-1:0] ap_base = field_start ? '0 : ap_acc;
  wire [CW-1:0] ff_base = field_start ? '0 : ff_acc;
  wire [CW-1:0] ap_nxt  = ap_en ? crc_step(ap_base, din) : ap_base;
  wire [CW-1:0] ff_nxt  = ff_en ? crc_step(ff_base, din) : ff_base;

  wire pk_ok   = pk_ld && (pk_word[DW-1] != pk_word[DW-2]) && (pk_word[1:0] == 2'b00);
  wire pk_ff   = (pk_sel >= 3'd3);
  wire [2:0] pk_k = pk_ff ? pk_sel - 3'd3 : pk_sel;
  wire pk_inrange = (pk_sel < 3'd6);

  wire ap_rv_now = rx_mode && rx_ap_v;
  wire ff_rv_now = rx_mode && rx_ff_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_acc <= '0;
      ff_acc <= '0;
    end else begin
      ap_acc <= ap_nxt;
      ff_acc <= ff_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ap_x <= '0;
      rx_ff_x <= '0;
      rx_ap_v <= 1'b0;
      rx_ff_v <= 1'b0;
    end else begin
      if (field_end) begin
        rx_ap_v <= 1'b0;
        rx_ff_v <= 1'b0;
      end
      if (pk_ok && pk_inrange) begin
        if (pk_ff) begin
          rx_ff_x[pk_k*CHUNK +: CHUNK] <= pk_word[CHUNK+1:2];
          if (pk_k == 3'(NW-1)) rx_ff_v <= pk_word[DW-2];
        end else begin
          rx_ap_x[pk_k*CHUNK +: CHUNK] <= pk_word[CHUNK+1:2];
          if (pk_k == 3'(NW-1)) rx_ap_v <= pk_word[DW-2];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      ap_crc  <= '0;
      ff_crc  <= '0;
      ap_mis  <= 1'b0;
      ff_mis  <= 1'b0;
      ap_rxv  <= 1'b0;
      ff_rxv  <= 1'b0;
    end else begin
      res_vld <= field_end;
      if (field_end) begin
        ap_crc <= ap_nxt;
        ff_crc <= ff_nxt;
        ap_rxv <= ap_rv_now;
        ff_rxv <= ff_rv_now;
        ap_mis <= ap_rv_now && (rx_ap_x[CW-1:0] != ap_nxt);
        ff_mis <= ff_rv_now && (rx_ff_x[CW-1:0] != ff_nxt);
      end
    end
  end

  assign tx_ap_pk = pack(ap_crc, 1'b1);
  assign tx_ff_pk = pack(ff_crc, 1'b1);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !field_end |=> $stable(ap_crc) && $stable(ff_crc) && $stable(ap_mis) && $stable(ff_mis));

  // R9
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_end && !rx_mode |=> !ap_mis && !ff_mis && !ap_rxv && !ff_rxv);

  // R8
  mis_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_mis |-> ap_rxv) and (ff_mis |-> ff_rxv));

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_start && !ap_en && !ff_en |=> ap_acc == '0 && ff_acc == '0);

  // R8
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_end && !pk_ld |=> !rx_ap_v && !rx_ff_v);

endmodule

// File: tb/field_crc_gen_tb_top.sv
module field_crc_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_mode = 1'b0;
  logic [9:0] din = '0;
  logic ap_en = 1'b0, ff_en = 1'b0, field_start = 1'b0, field_end = 1'b0;
  logic pk_ld = 1'b0;
  logic [2:0] pk_sel = '0;
  logic [9:0] pk_word = '0;
  logic res_vld, ap_mis, ff_mis, ap_rxv, ff_rxv;
  logic [15:0] ap_crc, ff_crc;
  logic [29:0] tx_ap_pk, tx_ff_pk;

  int n_chk = 0, n_fail = 0, pushed = 0, popped = 0;
  logic [95:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  field_crc_gen dut_i (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .din(din), .ap_en(ap_en), .ff_en(ff_en),
    .field_start(field_start), .field_end(field_end), .pk_ld(pk_ld), .pk_sel(pk_sel),
    .pk_word(pk_word), .res_vld(res_vld), .ap_crc(ap_crc), .ff_crc(ff_crc),
    .ap_mis(ap_mis), .ff_mis(ff_mis), .ap_rxv(ap_rxv), .ff_rxv(ff_rxv),
    .tx_ap_pk(tx_ap_pk), .tx_ff_pk(tx_ff_pk));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [9:0] w);
    logic [9:0] v;
    logic [15:0] s;
    v = (w >= 10'h3FC) ? 10'h3FF : w;
    s = c;
    for (int b = 0; b < 10; b++) begin
      if (v[b] != s[15]) s = (s << 1) ^ 16'h1021;
      else s = s << 1;
    end
    return s;
  endfunction

  function automatic logic [9:0] ref_word(input logic [15:0] c, input int k, input bit v);
    logic [17:0] x;
    logic [5:0] ch;
    logic p;
    x = {2'b00, c};
    ch = x[6*k +: 6];
    p = (k == 2) ? v : ^ch;
    return {~p, p, ch, 2'b00};
  endfunction

  function automatic logic [29:0] ref_pack(input logic [15:0] c);
    return {ref_word(c, 2, 1'b1), ref_word(c, 1, 1'b1), ref_word(c, 0, 1'b1)};
  endfunction

  function automatic logic [9:0] wgen(input int kind, input int i);
    case (kind)
      1: return (i % 2 == 0) ? 10'(10'h3FC + (i / 2) % 4) : 10'((i * 13 + 7) % 1024);
      2: return 10'h3FF;
      3: return 10'h3FC + 10'(i % 4);
      4: return 10'h3FB;
      default: return 10'((i * 37 + 5) % 1024);
    endcase
  endfunction

  // Monitor: compares each result the cycle res_vld is high (R5 timing)
  always @(negedge clk) begin
    if (res_vld) begin
      logic [95:0] e;
      string t;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected result", 64'(res_vld), 64'd0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        popped++;
        chk(ap_crc == e[95:80], {t, " R1 ap_crc"}, 64'(ap_crc), 64'(e[95:80]));
        chk(ff_crc == e[79:64], {t, " R1 ff_crc"}, 64'(ff_crc), 64'(e[79:64]));
        chk({ap_mis, ff_mis} == e[63:62], {t, " R7 mismatch"}, 64'({ap_mis, ff_mis}), 64'(e[63:62]));
        chk({ap_rxv, ff_rxv} == e[61:60], {t, " R8 rx valid"}, 64'({ap_rxv, ff_rxv}), 64'(e[61:60]));
        chk(tx_ap_pk == e[59:30], {t, " R6 ap words"}, 64'(tx_ap_pk), 64'(e[59:30]));
        chk(tx_ff_pk == e[29:0], {t, " R6 ff words"}, 64'(tx_ff_pk), 64'(e[29:0]));
      end
    end
  end

  task automatic load_word(input int slot, input logic [9:0] w);
    @(negedge clk);
    ap_en = 1'b0; ff_en = 1'b0; field_start = 1'b0;
    pk_ld = 1'b1; pk_sel = 3'(slot); pk_word = w;
    @(negedge clk);
    pk_ld = 1'b0;
  endtask

  // Driver: feeds one field, queues the expected record, closes the field
  task automatic run_field(input string tag, input bit rx, input int kind, input int n,
                           input int a0, input int a1, input int f0, input int f1,
                           input int pre, input bit send_pkt, input bit vbit,
                           input bit bad_ap, input bit bad_ff, input bit bad_frame);
    logic [15:0] eap, eff, pap, pff;
    bit rv_ap, rv_ff;
    eap = '0; eff = '0;
    rx_mode = rx;
    for (int i = 0; i < pre; i++) begin
      @(negedge clk);
      din = wgen(0, i + 100); ap_en = 1'b1; ff_en = 1'b1; field_start = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      din = wgen(kind, i);
      ap_en = (i >= a0 && i < a1);
      ff_en = (i >= f0 && i < f1);
      field_start = (i == 0);
      if (ap_en) eap = ref_crc(eap, din);
      if (ff_en) eff = ref_crc(eff, din);
    end
    if (n == 0) begin
      @(negedge clk);
      ap_en = 1'b0; ff_en = 1'b0; field_start = 1'b1;
    end
    pap = bad_ap ? eap ^ 16'h0100 : eap;
    pff = bad_ff ? eff ^ 16'h8000 : eff;
    if (send_pkt) begin
      for (int k = 0; k < 3; k++) load_word(k, ref_word(pap, k, vbit));
      for (int k = 0; k < 3; k++) load_word(k + 3, ref_word(pff, k, vbit));
      if (bad_frame) begin
        load_word(1, ref_word(pap ^ 16'h0040, 1, vbit) | 10'h001);
        load_word(4, ref_word(pff ^ 16'h0040, 1, vbit) ^ 10'h200);
      end
    end
    rv_ap = rx && send_pkt && vbit;
    rv_ff = rv_ap;
    exp_q.push_back({eap, eff, rv_ap && (pap != eap), rv_ff && (pff != eff), rv_ap, rv_ff,
                     ref_pack(eap), ref_pack(eff)});
    tag_q.push_back(tag);
    pushed++;
    @(negedge clk);
    ap_en = 1'b0; ff_en = 1'b0; field_start = 1'b0; din = 10'h2A5; field_end = 1'b1;
    @(negedge clk);
    field_end = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(res_vld == 1'b0, {tag, " R5 pulse ends"}, 64'(res_vld), 64'd0);
    chk(ap_crc == eap && ff_crc == eff, {tag, " R5 values hold"}, {32'd0, ap_crc, ff_crc}, {32'd0, eap, eff});
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    // R5 reset state
    chk(res_vld == 0 && ap_crc == 0 && ff_crc == 0, "R5 reset values", {ap_crc, ff_crc, 31'd0, res_vld}, 64'd0);
    chk({ap_mis, ff_mis, ap_rxv, ff_rxv} == 0, "R5 reset flags", 64'({ap_mis, ff_mis, ap_rxv, ff_rxv}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_field("R1 R3 tx basic",       1'b0, 0, 40, 10, 30, 0, 40, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_field("R2 recode mix",        1'b0, 1, 32, 4, 28, 0, 32, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_field("R2 all 3FF",           1'b0, 2, 12, 0, 12, 0, 12, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_field("R2 3FC..3FF",          1'b0, 3, 12, 0, 12, 0, 12, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_field("R2 3FB kept",          1'b0, 4, 12, 0, 12, 0, 12, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_field("R3 empty ap window",   1'b0, 0, 20, 5, 5, 2, 18, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_field("R4 restart after junk",1'b0, 0, 25, 3, 20, 0, 25, 9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_field("R7 rx match",          1'b1, 0, 36, 6, 30, 0, 36, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    run_field("R7 rx ap bad",         1'b1, 1, 36, 6, 30, 0, 36, 0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    run_field("R7 rx ff bad",         1'b1, 0, 30, 2, 20, 1, 29, 0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    run_field("R8 valid bit clear",   1'b1, 0, 30, 2, 20, 1, 29, 0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    run_field("R8 no packet",         1'b1, 0, 30, 2, 20, 1, 29, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_field("R9 tx ignores packet", 1'b0, 0, 30, 2, 20, 1, 29, 0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    run_field("R10 bad framing drop", 1'b1, 0, 30, 2, 20, 1, 29, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    chk(popped == pushed, "R5 result count", 64'(popped), 64'(pushed));
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule